// File: doc/BRIEF.md
# Privilege Level and Exception Entry Unit

This block keeps the current privilege level of a simple processor core and runs the hardware sequence that moves the core into an exception handler. The core hands it one request at a time: a sensitive operation (here, setting or clearing the interrupt enable), a direct privilege change, a load of the handler-table bank offset, or an exception with a vector number. The exception can be a software trap, a device interrupt or a core-detected fault. Privilege can be lowered directly, but it can only be raised by entering a handler. Each handler comes from a descriptor, so the new stack, instruction pointer and level are always loaded together.

Requests use a valid/ready handshake. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. While an entry sequence runs, `req_ready` is low and nothing is taken, so a source that wants its request served must hold it. After a double fault, `req_ready` stays low until reset. An entry reads one descriptor from an internal table of 16 entries. It then writes three context words downward through a fixed-timing memory write strobe with no back-pressure, and loads the new state. Handler descriptors are loaded through a separate table write port.

Top module: `priv_entry_unit`

## Requirements
- R1: After reset the level is 0, the instruction and stack pointers are 0, the interrupt enable is 0, the bank offset is 0, and busy and double-fault are low while `req_ready` is high.
- R2: Operation code 0 at level 0 sets the interrupt enable to `req_arg[0]` at the accepting edge. At level 3 it leaves the enable unchanged and instead causes a fault entry through vector FAULT_VEC (default 6).
- R3: Operation code 1 sets the level to `req_arg[1:0]` only when the target is 0 or 3 and is not numerically below the current level. Any other target (3 to 0, or 1 or 2) causes a fault entry through FAULT_VEC, and the level is not changed until that handler is loaded.
- R4: Operation code 2 at level 0 loads the bank offset from `req_arg`. At level 3 it causes a fault entry and the offset is kept.
- R5: Codes 3 (trap) and 5 (fault) always start an entry, and code 4 (interrupt) starts one only when the interrupt enable is 1. The descriptor used is (bank offset + vector) modulo 16. A masked interrupt has no effect.
- R6: Let S be the descriptor stack value. In the 2nd, 3rd and 4th cycles after acceptance, `mw_en` is high and the block writes the old level (zero-extended) at S-1, the request's `req_sp` at S-2 and the request's `req_ip` at S-3.
- R7: At the edge that ends the third write, and not before, level, instruction pointer and stack pointer become the descriptor level, the descriptor instruction pointer and S-3.
- R8: `busy` is high for exactly 4 cycles per entry and `req_ready` is low during them. A request presented then is not taken and changes nothing.
- R9: A descriptor whose present bit is 0, or whose level is 1 or 2, sets a sticky `dfault` one cycle after acceptance. No write follows, level and pointers are kept, and `req_ready` stays low until reset.
- R10: A table write with `tbl_sel` 0 stores the stack word and 1 stores the instruction word. Selector 2 stores the control word: bit 2 is the present bit and bits 1:0 are the level. Selector 3 changes nothing.
- R11: Operation codes 6 and 7 are accepted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 3 | Operation code |
| req_arg | input | VEC_W | Vector, level, enable bit or bank offset |
| req_ip | input | W | Instruction pointer of the requesting instruction |
| req_sp | input | W | Stack pointer at request time |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_idx | input | VEC_W | Descriptor index |
| tbl_sel | input | 2 | Descriptor word selector |
| tbl_wdata | input | W | Descriptor word data |
| mw_en | output | 1 | Context write strobe |
| mw_addr | output | W | Context write address |
| mw_data | output | W | Context write data |
| cur_lvl | output | 2 | Current privilege level |
| cur_ip | output | W | Handler instruction pointer last loaded |
| cur_sp | output | W | Stack pointer after the last entry |
| irq_en | output | 1 | Interrupt enable |
| busy | output | 1 | Entry sequence in progress |
| dfault | output | 1 | Sticky double fault |

## Verification
On every cycle, the assertions check four things. The level only ever holds 0 or 3, and a move from 3 to 0 comes only from a handler load. The context writes form one contiguous run with descending addresses. A double fault stays set and blocks any further write or acceptance. The bench's scenarios are needed for the rest: which privilege violations become fault entries, the bank-offset index arithmetic across all vectors, the exact pushed values and final pointers, the masking of interrupts, and requests that are dropped during busy.

// File: rtl/priv_pkg.sv
package priv_pkg;
  typedef enum logic [2:0] {
    OP_SENS   = 3'd0,
    OP_SETLVL = 3'd1,
    OP_TBASE  = 3'd2,
    OP_TRAP   = 3'd3,
    OP_IRQ    = 3'd4,
    OP_FAULT  = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_PUSH0, ST_PUSH1, ST_PUSH2, ST_HALT
  } st_e;

  localparam logic [1:0] LVL_K = 2'd0;
  localparam logic [1:0] LVL_U = 2'd3;
endpackage

// File: rtl/handler_table.sv
module handler_table #(
  parameter int W     = 16,
  parameter int VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [VEC_W-1:0] widx,
  input  logic [1:0]       wsel,
  input  logic [W-1:0]     wdata,
  input  logic [VEC_W-1:0] ridx,
  output logic [W-1:0]     r_sp,
  output logic [W-1:0]     r_ip,
  output logic [2:0]       r_ctrl
);
  localparam int NVEC = 1 << VEC_W;

  logic [W-1:0] sp_m   [NVEC];
  logic [W-1:0] ip_m   [NVEC];
  logic [2:0]   ctrl_m [NVEC];

  for (genvar g = 0; g < NVEC; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sp_m[g]   <= '0;
        ip_m[g]   <= '0;
        ctrl_m[g] <= '0;
      end else if (we && widx == VEC_W'(g)) begin
        case (wsel)
          2'd0:    sp_m[g]   <= wdata;
          2'd1:    ip_m[g]   <= wdata;
          2'd2:    ctrl_m[g] <= wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  assign r_sp   = sp_m[ridx];
  assign r_ip   = ip_m[ridx];
  assign r_ctrl = ctrl_m[ridx];
endmodule

// File: rtl/priv_check.sv
module priv_check
  import priv_pkg::*;
#(
  parameter int VEC_W     = 4,
  parameter int FAULT_VEC = 6
) (
  input  op_e              op,
  input  logic [VEC_W-1:0] arg,
  input  logic [1:0]       lvl,
  input  logic             irq_en,
  output logic             apply,
  output logic             entry,
  output logic [VEC_W-1:0] evec
);
  logic priv;
  logic viol;
  logic tgt_ok;

  always_comb begin
    priv   = (lvl == LVL_K);
    tgt_ok = (arg[1:0] == LVL_K || arg[1:0] == LVL_U) && (arg[1:0] >= lvl);
    viol   = 1'b0;
    apply  = 1'b0;
    entry  = 1'b0;
    evec   = arg;
    case (op)
      OP_SENS, OP_TBASE: if (priv) apply = 1'b1; else viol = 1'b1;
      OP_SETLVL:         if (tgt_ok) apply = 1'b1; else viol = 1'b1;
      OP_TRAP, OP_FAULT: entry = 1'b1;
      OP_IRQ:            entry = irq_en;
      default:           ;
    endcase
    if (viol) begin
      entry = 1'b1;
      evec  = VEC_W'(FAULT_VEC);
    end
  end
endmodule

// File: rtl/entry_seq.sv
module entry_seq
  import priv_pkg::*;
#(
  parameter int W     = 16,
  parameter int VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  op_e              op,
  input  logic [VEC_W-1:0] arg,
  input  logic             apply,
  input  logic             entry,
  input  logic [VEC_W-1:0] evec,
  input  logic [W-1:0]     ctx_ip,
  input  logic [W-1:0]     ctx_sp,
  input  logic [W-1:0]     d_sp,
  input  logic [W-1:0]     d_ip,
  input  logic [2:0]       d_ctrl,
  output logic [VEC_W-1:0] tidx,
  output logic             mw_en,
  output logic [W-1:0]     mw_addr,
  output logic [W-1:0]     mw_data,
  output logic [1:0]       lvl,
  output logic [W-1:0]     ip,
  output logic [W-1:0]     sp,
  output logic             irq_en,
  output logic             busy,
  output logic             ready,
  output logic             dfault
);
  st_e              st_q;
  logic [VEC_W-1:0] idx_q, tbase_q;
  logic [1:0]       lvl_q, olvl_q, nlvl_q;
  logic [W-1:0]     ip_q, sp_q, oip_q, osp_q, nsp_q, nip_q;
  logic             ie_q, df_q;
  logic             d_ok;

  assign d_ok = d_ctrl[2] && (d_ctrl[1:0] == LVL_K || d_ctrl[1:0] == LVL_U);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      tbase_q <= '0;
      lvl_q   <= LVL_K;
      olvl_q  <= LVL_K;
      nlvl_q  <= LVL_K;
      ip_q    <= '0;
      sp_q    <= '0;
      oip_q   <= '0;
      osp_q   <= '0;
      nsp_q   <= '0;
      nip_q   <= '0;
      ie_q    <= 1'b0;
      df_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (acc) begin
          if (entry) begin
            st_q   <= ST_READ;
            idx_q  <= tbase_q + evec;
            olvl_q <= lvl_q;
            oip_q  <= ctx_ip;
            osp_q  <= ctx_sp;
          end else if (apply) begin
            case (op)
              OP_SENS:   ie_q    <= arg[0];
              OP_SETLVL: lvl_q   <= arg[1:0];
              OP_TBASE:  tbase_q <= arg;
              default:   ;
            endcase
          end
        end
        ST_READ: begin
          if (d_ok) begin
            nsp_q  <= d_sp;
            nip_q  <= d_ip;
            nlvl_q <= d_ctrl[1:0];
            st_q   <= ST_PUSH0;
          end else begin
            df_q <= 1'b1;
            st_q <= ST_HALT;
          end
        end
        ST_PUSH0: st_q <= ST_PUSH1;
        ST_PUSH1: st_q <= ST_PUSH2;
        ST_PUSH2: begin
          lvl_q <= nlvl_q;
          ip_q  <= nip_q;
          sp_q  <= nsp_q - W'(3);
          st_q  <= ST_IDLE;
        end
        default: st_q <= st_q;
      endcase
    end
  end

  always_comb begin
    mw_en   = 1'b0;
    mw_addr = nsp_q - W'(1);
    mw_data = {{(W-2){1'b0}}, olvl_q};
    case (st_q)
      ST_PUSH0: mw_en = 1'b1;
      ST_PUSH1: begin
        mw_en   = 1'b1;
        mw_addr = nsp_q - W'(2);
        mw_data = osp_q;
      end
      ST_PUSH2: begin
        mw_en   = 1'b1;
        mw_addr = nsp_q - W'(3);
        mw_data = oip_q;
      end
      default: ;
    endcase
  end

  assign tidx   = idx_q;
  assign lvl    = lvl_q;
  assign ip     = ip_q;
  assign sp     = sp_q;
  assign irq_en = ie_q;
  assign busy   = (st_q == ST_READ) || (st_q == ST_PUSH0) ||
                  (st_q == ST_PUSH1) || (st_q == ST_PUSH2);
  assign ready  = (st_q == ST_IDLE);
  assign dfault = df_q;

  // R3
  lvl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q == LVL_K || lvl_q == LVL_U);

  // R7
  raise_only_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_K && $past(lvl_q) == LVL_U) |-> $past(st_q) == ST_PUSH2);

  // R6
  push_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_en && !$past(mw_en)) |=> mw_en && mw_addr == $past(mw_addr) - W'(1));

  // R7
  hold_during_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lvl_q) && $stable(ip_q) && $stable(sp_q));

  // R9
  dfault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dfault |=> dfault && !mw_en && !ready);
endmodule

// File: rtl/priv_entry_unit.sv
module priv_entry_unit
  import priv_pkg::*;
#(
  parameter int W         = 16,
  parameter int VEC_W     = 4,
  parameter int FAULT_VEC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [VEC_W-1:0] req_arg,
  input  logic [W-1:0]     req_ip,
  input  logic [W-1:0]     req_sp,
  input  logic             tbl_we,
  input  logic [VEC_W-1:0] tbl_idx,
  input  logic [1:0]       tbl_sel,
  input  logic [W-1:0]     tbl_wdata,
  output logic             mw_en,
  output logic [W-1:0]     mw_addr,
  output logic [W-1:0]     mw_data,
  output logic [1:0]       cur_lvl,
  output logic [W-1:0]     cur_ip,
  output logic [W-1:0]     cur_sp,
  output logic             irq_en,
  output logic             busy,
  output logic             dfault
);
  op_e              op;
  logic             acc, apply, entry;
  logic [VEC_W-1:0] evec, tidx;
  logic [W-1:0]     d_sp, d_ip;
  logic [2:0]       d_ctrl;

  assign op  = op_e'(req_op);
  assign acc = req_valid && req_ready;

  handler_table #(.W(W), .VEC_W(VEC_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .wsel(tbl_sel),
    .wdata(tbl_wdata), .ridx(tidx), .r_sp(d_sp), .r_ip(d_ip), .r_ctrl(d_ctrl)
  );

  priv_check #(.VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)) u_chk (
    .op(op), .arg(req_arg), .lvl(cur_lvl), .irq_en(irq_en),
    .apply(apply), .entry(entry), .evec(evec)
  );

  entry_seq #(.W(W), .VEC_W(VEC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .op(op), .arg(req_arg),
    .apply(apply), .entry(entry), .evec(evec),
    .ctx_ip(req_ip), .ctx_sp(req_sp),
    .d_sp(d_sp), .d_ip(d_ip), .d_ctrl(d_ctrl), .tidx(tidx),
    .mw_en(mw_en), .mw_addr(mw_addr), .mw_data(mw_data),
    .lvl(cur_lvl), .ip(cur_ip), .sp(cur_sp), .irq_en(irq_en),
    .busy(busy), .ready(req_ready), .dfault(dfault)
  );
endmodule

// File: tb/priv_entry_unit_bench.sv
`timescale 1ns/1ps
module priv_entry_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [2:0]  req_op = 0;
  logic [3:0]  req_arg = 0;
  logic [15:0] req_ip = 0, req_sp = 0;
  logic        tbl_we = 0;
  logic [3:0]  tbl_idx = 0;
  logic [1:0]  tbl_sel = 0;
  logic [15:0] tbl_wdata = 0;
  logic        mw_en;
  logic [15:0] mw_addr, mw_data;
  logic [1:0]  cur_lvl;
  logic [15:0] cur_ip, cur_sp;
  logic        irq_en, busy, dfault;

  int checks = 0, fails = 0;
  logic [1:0]  bl;
  logic [15:0] bip, bsp;
  logic        bie;
  int          btb;

  always #5 clk = ~clk;

  priv_entry_unit u_priv_entry_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_arg(req_arg), .req_ip(req_ip), .req_sp(req_sp),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata),
    .mw_en(mw_en), .mw_addr(mw_addr), .mw_data(mw_data), .cur_lvl(cur_lvl),
    .cur_ip(cur_ip), .cur_sp(cur_sp), .irq_en(irq_en), .busy(busy), .dfault(dfault)
  );

  function automatic logic [15:0] dsp(int k); return 16'(32'h8000 + k * 256); endfunction
  function automatic logic [15:0] dip(int k); return 16'(32'h4000 + k * 17); endfunction
  function automatic logic [1:0]  dlv(int k); return (k % 2 == 1) ? 2'd3 : 2'd0; endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic twr(input int idx, input int sel, input logic [15:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 4'(idx); tbl_sel = 2'(sel); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic issue(input int op, input int arg, input logic [15:0] ip, input logic [15:0] sp);
    @(negedge clk);
    req_valid = 1; req_op = 3'(op); req_arg = 4'(arg); req_ip = ip; req_sp = sp;
    @(negedge clk);
    req_valid = 0;
  endtask

  // Entry through descriptor idx; optionally presents a competing request during busy.
  task automatic entry_check(input int op, input int arg, input logic [15:0] ip,
                             input logic [15:0] sp, input int idx, input bit inj, input string tag);
    logic [15:0] s;
    s = dsp(idx);
    issue(op, arg, ip, sp);
    if (inj) begin req_valid = 1; req_op = 3'd0; req_arg = 4'd0; end
    chk(busy === 1'b1, {tag, " R8 busy"}, 32'(busy), 1);
    chk(mw_en === 1'b0, {tag, " R6 idle read"}, 32'(mw_en), 0);
    if (inj) chk(req_ready === 1'b0, {tag, " R8 ready"}, 32'(req_ready), 0);
    @(negedge clk);
    chk(mw_en === 1'b1 && mw_addr === s - 16'd1, {tag, " R6 push0 addr"}, {mw_en, 15'(mw_addr)}, {1'b1, 15'(s - 16'd1)});
    chk(mw_data === 16'(bl), {tag, " R6 push0 data"}, mw_data, 32'(bl));
    chk(cur_lvl === bl, {tag, " R7 early"}, cur_lvl, bl);
    @(negedge clk);
    chk(mw_en === 1'b1 && mw_addr === s - 16'd2 && mw_data === sp, {tag, " R6 push1"}, mw_data, sp);
    @(negedge clk);
    chk(mw_en === 1'b1 && mw_addr === s - 16'd3 && mw_data === ip, {tag, " R6 push2"}, mw_data, ip);
    chk(busy === 1'b1 && cur_ip === bip, {tag, " R7 not yet"}, cur_ip, bip);
    if (inj) req_valid = 0;
    @(negedge clk);
    bl = dlv(idx); bip = dip(idx); bsp = s - 16'd3;
    chk(cur_lvl === bl, {tag, " R7 lvl"}, cur_lvl, bl);
    chk(cur_ip === bip, {tag, " R7 ip"}, cur_ip, bip);
    chk(cur_sp === bsp, {tag, " R7 sp"}, cur_sp, bsp);
    chk(busy === 1'b0 && mw_en === 1'b0, {tag, " R8 done"}, {busy, mw_en}, 0);
    chk(irq_en === bie, {tag, " R8 side req dropped"}, irq_en, bie);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(cur_lvl === 2'd0, "R1 lvl", cur_lvl, 0);
    chk(cur_ip === 16'd0 && cur_sp === 16'd0, "R1 ptrs", {cur_ip, cur_sp}, 0);
    chk(irq_en === 1'b0 && busy === 1'b0 && dfault === 1'b0, "R1 flags", {irq_en, busy, dfault}, 0);
    chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
    bl = 0; bip = 0; bsp = 0; bie = 0; btb = 0;

    // R10 table load: words 0 sp, 1 ip, 2 ctrl {present, lvl}
    for (int k = 0; k < 16; k++) begin
      twr(k, 0, dsp(k));
      twr(k, 1, dip(k));
      twr(k, 2, {13'd0, (k != 15), dlv(k)});
    end
    twr(2, 3, 16'hFFFF); // R10 selector 3 must not disturb entry 2

    // R5 masked interrupt
    issue(4, 3, 16'h0, 16'h0);
    chk(busy === 1'b0, "R5 masked irq", busy, 0);
    @(negedge clk);
    chk(mw_en === 1'b0 && cur_lvl === 2'd0, "R5 masked irq idle", mw_en, 0);

    // R11 reserved codes
    issue(7, 1, 16'h0, 16'h0);
    chk(busy === 1'b0 && irq_en === 1'b0 && cur_lvl === 2'd0, "R11 rsv7", {busy, irq_en, cur_lvl}, 0);
    issue(6, 3, 16'h0, 16'h0);
    chk(busy === 1'b0 && cur_lvl === 2'd0, "R11 rsv6", {busy, cur_lvl}, 0);

    // R2 enable at level 0
    issue(0, 1, 16'h0, 16'h0);
    bie = 1;
    chk(irq_en === 1'b1, "R2 set enable", irq_en, 1);

    // R5 sweep, bank offset 0; R10 entry 2 intact shows selector 3 ignored
    for (int v = 0; v < 15; v++) begin
      int op;
      op = (v % 3 == 0) ? 3 : (v % 3 == 1) ? 4 : 5;
      entry_check(op, v, 16'(16'h1000 + v), 16'(16'h2000 + 2 * v), v, 0, "R5 R10 sweepA");
    end

    // R4 load offset 5 at level 0 (level now dlv(14)=0)
    issue(2, 5, 16'h0, 16'h0);
    btb = 5;
    chk(busy === 1'b0, "R4 offset load no entry", busy, 0);
    for (int v = 0; v < 16; v++) begin
      if (v != 10)
        entry_check(3, v, 16'(16'h3000 + v), 16'(16'h2100 + v), (v + btb) % 16, 0, "R4 R5 sweepB");
    end

    // R8 request during busy is dropped (trap 1 -> idx 6, level 0)
    entry_check(3, 1, 16'h5555, 16'h2AAA, 6, 1, "R8 inject");

    // R3 lower directly
    issue(1, 3, 16'h0, 16'h0);
    bl = 3;
    chk(cur_lvl === 2'd3 && busy === 1'b0, "R3 lower", cur_lvl, 3);
    // R3 raise faults -> idx (5+6)%16 = 11
    entry_check(1, 0, 16'h0A01, 16'h3001, 11, 0, "R3 raise fault");
    // R2 sensitive at level 3 faults, enable kept
    entry_check(0, 0, 16'h0A02, 16'h3002, 11, 0, "R2 user sens");
    // R4 offset load at level 3 faults
    entry_check(2, 0, 16'h0A03, 16'h3003, 11, 0, "R4 user tbase");
    // R4 offset unchanged: vector 0 still hits 5
    entry_check(3, 0, 16'h0A04, 16'h3004, 5, 0, "R4 offset kept");
    entry_check(3, 1, 16'h0A05, 16'h3005, 6, 0, "R3 back to 0");
    // R3 illegal target 2 at level 0
    entry_check(1, 2, 16'h0A06, 16'h3006, 11, 0, "R3 bad target");

    // R9 double fault: vector 10 -> idx 15, not present
    issue(3, 10, 16'h0B00, 16'h3100);
    @(negedge clk);
    chk(dfault === 1'b1, "R9 dfault set", dfault, 1);
    chk(mw_en === 1'b0 && busy === 1'b0 && req_ready === 1'b0, "R9 stopped", {mw_en, busy, req_ready}, 0);
    chk(cur_lvl === bl && cur_ip === bip && cur_sp === bsp, "R9 state kept", cur_sp, bsp);
    @(negedge clk);
    req_valid = 1; req_op = 3'd0; req_arg = 4'd0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(dfault === 1'b1 && mw_en === 1'b0 && irq_en === 1'b1, "R9 sticky", {dfault, mw_en, irq_en}, 3'b101);
    end
    req_valid = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule